// File: doc/BRIEF.md
# Compare and Condition Evaluator

This block compares two operands by subtracting the second (S) from the first (D) and keeping only the status flags of that subtraction, never the difference itself. It produces six flags: carry (borrow), zero, sign, overflow, auxiliary (nibble borrow) and parity. It then evaluates a 4-bit condition code against those flags and returns one true/false bit. A sequencer can use that bit for a conditional branch decision or for a set-on-condition result.

A select input switches the flag source. When the select is high, the comparison result is ignored and the condition code is tested against a flag vector supplied from outside. This models decisions that are based on flags left by an earlier operation. Every result is registered, and a done strobe marks the cycle in which a new result is present.

Top module: `cmp_cond_unit`

## Requirements
- R1: For a compare (valid_i=1, ext_sel_i=0), the flags reflect D-S on WIDTH bits. CF is 1 exactly when D<S unsigned. ZF is 1 when D==S. SF is the top bit of the difference. OF is 1 when the signed difference does not fit in WIDTH bits.
- R2: AF is 1 when the low nibble of D is below the low nibble of S (borrow out of bit 3). PF is 1 when bits 7:0 of the difference hold an even number of ones.
- R3: The condition codes are 0 overflow, 1 not overflow, 2 below (CF), 3 above-or-equal, 4 equal (ZF), 5 not equal, 6 below-or-equal (CF|ZF), 7 above, 8 sign (SF), 9 not sign, 10 parity even (PF), 11 parity odd, 12 less (SF^OF), 13 greater-or-equal, 14 less-or-equal ((SF^OF)|ZF), 15 greater. An odd code is the negation of the code one below it.
- R4: With ext_sel_i=1 on a valid cycle, the operands are ignored. flags_o takes the value of ext_flags_i, and the condition is evaluated against ext_flags_i.
- R5: done_o is high in exactly the cycle after each cycle with valid_i=1, and the results of that request are on the outputs in that same cycle.
- R6: In a cycle after one without valid_i, flags_o and cond_true_o hold their values and done_o is 0.
- R7: After reset, flags_o, cond_true_o and done_o are all 0.
- R8: The flag vector layout, used by both flags_o and ext_flags_i, is bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF.
- R9: For compares, the signed codes (12 to 15) agree with the signed order of D and S, and the unsigned codes (2, 3, 6, 7) agree with their unsigned order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| ext_sel_i | input | 1 | 1: test ext_flags_i instead of comparing |
| op_d_i | input | 16 | Minuend operand D |
| op_s_i | input | 16 | Subtrahend operand S |
| cond_i | input | 4 | Condition code |
| ext_flags_i | input | 6 | Externally supplied flags |
| flags_o | output | 6 | Registered flags |
| cond_true_o | output | 1 | Registered condition result |
| done_o | output | 1 | Result strobe |

## Verification
The block has one register stage, so the flags, the condition bit and the done strobe for a request applied before a rising edge all appear right after that edge. The bench drives inputs on falling edges. At each falling edge it first advances its reference model using the inputs applied one falling edge earlier, then compares all three outputs. This keeps the expected value exactly one edge behind the stimulus. The bench also checks that cycles without a request leave the outputs untouched. For compares, it cross-checks the signed and unsigned condition results against integer ordering of the operands.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int unsigned FLAG_W = 6;

  // bit0 cf .. bit5 of_f
  typedef struct packed {
    logic of_f;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  // cond code bits [3:1]; bit 0 negates
  typedef enum logic [2:0] {
    BASE_OVF  = 3'd0,
    BASE_BLW  = 3'd1,
    BASE_EQ   = 3'd2,
    BASE_BE   = 3'd3,
    BASE_SGN  = 3'd4,
    BASE_PAR  = 3'd5,
    BASE_LT   = 3'd6,
    BASE_LE   = 3'd7
  } cond_base_e;
endpackage

// File: rtl/cmp_sub_flags.sv
module cmp_sub_flags
  import cmp_cond_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_d_i,
  input  logic [WIDTH-1:0] op_s_i,
  output flags_t           flags_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] diff_ext;
  logic [4:0]     nib_diff;
  logic [WIDTH-1:0] res;

  assign diff_ext = {1'b0, op_d_i} - {1'b0, op_s_i};
  assign nib_diff = {1'b0, op_d_i[3:0]} - {1'b0, op_s_i[3:0]};
  assign res      = diff_ext[WIDTH-1:0];

  always_comb begin
    flags_o.cf   = diff_ext[WIDTH];
    flags_o.zf   = (res == '0);
    flags_o.sf   = res[MSB];
    flags_o.of_f = (op_d_i[MSB] ^ op_s_i[MSB]) & (op_d_i[MSB] ^ res[MSB]);
    flags_o.af   = nib_diff[4];
    flags_o.pf   = ~^res[7:0];
  end

  // R1
  always_comb begin
    if (flags_o.zf) zero_no_borrow_chk: assert (!flags_o.cf);
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cmp_cond_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [3:0] cond_i,
  output logic       hit_o
);
  cond_base_e base_sel;
  logic       base_hit;
  logic       lt_s;

  assign base_sel = cond_base_e'(cond_i[3:1]);
  assign lt_s     = flags_i.sf ^ flags_i.of_f;

  always_comb begin
    unique case (base_sel)
      BASE_OVF: base_hit = flags_i.of_f;
      BASE_BLW: base_hit = flags_i.cf;
      BASE_EQ:  base_hit = flags_i.zf;
      BASE_BE:  base_hit = flags_i.cf | flags_i.zf;
      BASE_SGN: base_hit = flags_i.sf;
      BASE_PAR: base_hit = flags_i.pf;
      BASE_LT:  base_hit = lt_s;
      BASE_LE:  base_hit = lt_s | flags_i.zf;
      default:  base_hit = 1'b0;
    endcase
  end

  assign hit_o = base_hit ^ cond_i[0];
endmodule

// File: rtl/cmp_cond_unit.sv
module cmp_cond_unit
  import cmp_cond_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ext_sel_i,
  input  logic [WIDTH-1:0]  op_d_i,
  input  logic [WIDTH-1:0]  op_s_i,
  input  logic [3:0]        cond_i,
  input  logic [FLAG_W-1:0] ext_flags_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              cond_true_o,
  output logic              done_o
);
  flags_t cmp_flags;
  flags_t sel_flags;
  logic   hit;

  cmp_sub_flags #(.WIDTH(WIDTH)) u_sub (
    .op_d_i (op_d_i),
    .op_s_i (op_s_i),
    .flags_o(cmp_flags)
  );

  assign sel_flags = ext_sel_i ? flags_t'(ext_flags_i) : cmp_flags;

  cond_eval u_cond (
    .flags_i(sel_flags),
    .cond_i (cond_i),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o     <= '0;
      cond_true_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        flags_o     <= sel_flags;
        cond_true_o <= hit;
      end
    end
  end

  // R5
  done_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R6
  idle_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(flags_o) && $stable(cond_true_o)));
  // R1
  equal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ext_sel_i && op_d_i == op_s_i) |=> (flags_o[3] && !flags_o[0]));
  // R1
  below_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ext_sel_i && op_d_i < op_s_i) |=> flags_o[0]);
  // R4
  ext_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ext_sel_i) |=> (flags_o == $past(ext_flags_i)));
endmodule

// File: tb/cmp_cond_unit_tb_top.sv
module cmp_cond_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ext_sel_i = 1'b0;
  logic [15:0] op_d_i = '0;
  logic [15:0] op_s_i = '0;
  logic [3:0]  cond_i = '0;
  logic [5:0]  ext_flags_i = '0;
  logic [5:0]  flags_o;
  logic        cond_true_o;
  logic        done_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  cmp_cond_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ext_sel_i(ext_sel_i),
    .op_d_i(op_d_i), .op_s_i(op_s_i), .cond_i(cond_i), .ext_flags_i(ext_flags_i),
    .flags_o(flags_o), .cond_true_o(cond_true_o), .done_o(done_o)
  );

  // reference state
  int    m_flags = 0;
  int    m_cond = 0;
  int    m_done = 0;
  // pending stimulus (applied at last negedge)
  int    p_valid = 0, p_ext = 0, p_d = 0, p_s = 0, p_cc = 0, p_ef = 0;
  string p_tag = "R7";
  int    p_order = -1; // expected signed/unsigned cross check result, -1 none

  function automatic int ref_flags(int d, int s);
    int diff, sd, ss, sres, cf, zf, sf, of_v, af, pf, ones;
    diff = (d - s) & 32'hFFFF;
    sd = (d >= 32768) ? d - 65536 : d;
    ss = (s >= 32768) ? s - 65536 : s;
    sres = sd - ss;
    cf = (d < s) ? 1 : 0;
    zf = (diff == 0) ? 1 : 0;
    sf = (diff >= 32768) ? 1 : 0;
    of_v = (sres > 32767 || sres < -32768) ? 1 : 0;
    af = ((d % 16) < (s % 16)) ? 1 : 0;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (diff >> k) & 1;
    pf = (ones % 2 == 0) ? 1 : 0;
    return cf + 2*pf + 4*af + 8*zf + 16*sf + 32*of_v;
  endfunction

  function automatic int ref_cond(int fl, int cc);
    int cf, pf, zf, sf, of_v;
    cf = fl & 1; pf = (fl >> 1) & 1; zf = (fl >> 3) & 1;
    sf = (fl >> 4) & 1; of_v = (fl >> 5) & 1;
    case (cc)
      0:  return of_v;
      1:  return 1 - of_v;
      2:  return cf;
      3:  return 1 - cf;
      4:  return zf;
      5:  return 1 - zf;
      6:  return (cf == 1 || zf == 1) ? 1 : 0;
      7:  return (cf == 0 && zf == 0) ? 1 : 0;
      8:  return sf;
      9:  return 1 - sf;
      10: return pf;
      11: return 1 - pf;
      12: return (sf != of_v) ? 1 : 0;
      13: return (sf == of_v) ? 1 : 0;
      14: return (sf != of_v || zf == 1) ? 1 : 0;
      default: return (sf == of_v && zf == 0) ? 1 : 0;
    endcase
  endfunction

  // integer-order prediction for R9 cross check
  function automatic int order_pred(int d, int s, int cc);
    int sd, ss;
    sd = (d >= 32768) ? d - 65536 : d;
    ss = (s >= 32768) ? s - 65536 : s;
    case (cc)
      2:  return (d < s) ? 1 : 0;
      3:  return (d >= s) ? 1 : 0;
      6:  return (d <= s) ? 1 : 0;
      7:  return (d > s) ? 1 : 0;
      12: return (sd < ss) ? 1 : 0;
      13: return (sd >= ss) ? 1 : 0;
      14: return (sd <= ss) ? 1 : 0;
      15: return (sd > ss) ? 1 : 0;
      default: return -1;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: advance model, compare, then drive next stimulus
  task automatic step(int v, int e, int d, int s, int cc, int ef, string tag);
    @(negedge clk_i);
    m_done = p_valid;
    if (p_valid != 0) begin
      m_flags = (p_ext != 0) ? p_ef : ref_flags(p_d, p_s);
      m_cond  = ref_cond(m_flags, p_cc);
    end
    check(p_tag, "done_o", int'(done_o), m_done);
    check(p_tag, "flags_o", int'(flags_o), m_flags);
    check(p_tag, "cond_true_o", int'(cond_true_o), m_cond);
    if (p_order >= 0) check("R9", "order cond", int'(cond_true_o), p_order);
    valid_i = v[0]; ext_sel_i = e[0];
    op_d_i = d[15:0]; op_s_i = s[15:0]; cond_i = cc[3:0]; ext_flags_i = ef[5:0];
    p_valid = v; p_ext = e; p_d = d & 32'hFFFF; p_s = s & 32'hFFFF;
    p_cc = cc & 15; p_ef = ef & 63; p_tag = tag;
    p_order = (v != 0 && e == 0) ? order_pred(p_d, p_s, p_cc) : -1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R7 reset state
    check("R7", "flags_o reset", int'(flags_o), 0);
    check("R7", "cond_true_o reset", int'(cond_true_o), 0);
    check("R7", "done_o reset", int'(done_o), 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R7");
    // R1 R2 R8: 1234h vs ABCDh -> CF=1 AF=1, others 0
    step(1, 0, 16'h1234, 16'hABCD, 2, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk_i);
    check("R8", "example flags", int'(flags_o), 6'b000101);
    check("R6", "hold done", int'(done_o), 0);
    // R1 equal operands
    step(1, 0, 16'h5A5A, 16'h5A5A, 4, 0, "R1");
    // R1 signed overflow: 7FFF - FFFF
    step(1, 0, 16'h7FFF, 16'hFFFF, 0, 0, "R1");
    step(1, 0, 16'h8000, 16'h0001, 12, 0, "R1");
    // R2 nibble borrow and parity
    step(1, 0, 16'h0010, 16'h0001, 10, 0, "R2");
    step(1, 0, 16'h00FF, 16'h0000, 11, 0, "R2");
    // R3 sweep every code on several operand pairs
    for (int cc = 0; cc < 16; cc++) begin
      step(1, 0, 16'h1234, 16'hABCD, cc, 0, "R3");
      step(1, 0, 16'hABCD, 16'h1234, cc, 0, "R3");
      step(1, 0, 16'h4444, 16'h4444, cc, 0, "R3");
      step(1, 0, 16'h8000, 16'h7FFF, cc, 0, "R3");
    end
    // R4 external flags, operands ignored
    for (int ef = 0; ef < 64; ef += 7) begin
      for (int cc = 0; cc < 16; cc += 3)
        step(1, 1, 16'h0000, 16'hFFFF, cc, ef, "R4");
    end
    // R6 idle holds with moving inputs
    step(1, 0, 16'h0003, 16'h0009, 6, 0, "R6");
    step(0, 0, 16'hFFFF, 16'h0000, 1, 63, "R6");
    step(0, 1, 16'h1111, 16'h2222, 9, 21, "R6");
    // R5 back-to-back and pseudo-random mix
    begin
      int seed = 32'h1357;
      for (int i = 0; i < 600; i++) begin
        int a, b, c, f, v, e;
        seed = seed * 1103515245 + 12345;
        a = (seed >>> 8) & 16'hFFFF;
        seed = seed * 1103515245 + 12345;
        b = (seed >>> 8) & 16'hFFFF;
        if (i % 9 == 0) b = a;
        c = (seed >>> 4) & 15;
        f = (seed >>> 12) & 63;
        v = (i % 5 == 4) ? 0 : 1;
        e = (i % 7 == 3) ? 1 : 0;
        step(v, e, a, b, c, f, (e != 0) ? "R4" : "R5");
      end
    end
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R6");
    finish_run();
  end
endmodule